// File: doc/BRIEF.md
# PCIe TLP Trace Filter

This block sits beside a PCIe core and decides, header by header, whether a transaction-layer packet is handed to the trace record formatter. Software sets up a 20-bit source selector, a class mask, a direction code and a record-size select (short 4DW or long 8DW records), then requests a trace start. If the setup is legal, it is latched and held for the whole run. Each header seen at the core then comes with a valid strobe, its direction, its class, an inbound completion subtype, the root-port index it passed through and its requester ID. The block answers with a registered capture strobe.

The control path is a three-state machine. `ST_IDLE` waits for a start request. A start with a legal setup takes the transition *launch* to `ST_RUN`. A start with an illegal setup takes *reject* to `ST_ERR`. In `ST_RUN`, a stop request takes *halt* back to `ST_IDLE`, and a start request is ignored. In `ST_ERR`, a start with a legal setup takes *recover* to `ST_RUN` and an illegal one stays in place (*re-reject*). A stop request in `ST_ERR` takes *clear* back to `ST_IDLE`.

Top module: `tlp_trace_filter`

## Requirements
- R1: After reset, trace_active, config_error and capture are all 0.
- R2: A start request whose setup is illegal raises config_error on the next cycle and leaves trace_active at 0. The setup is illegal if any of these holds: the direction code is reserved (4DW: codes 4 to 15; 8DW: code 0 and codes 4 to 15), the class mask bits [2:0] are zero, class mask bits [7:3] are not zero, source selector bits [18:16] are not zero, or more than one class bit is set while the direction code includes outbound traffic (4DW codes 1 to 3, 8DW code 1). A start request with a legal setup sets trace_active on the next cycle. config_error and trace_active are never 1 together.
- R3: capture is 1 for exactly one cycle, on the cycle after a hdr_valid cycle whose header passes all filters while trace is active. capture is never 1 on the cycle after a cycle in which trace was inactive.
- R4: When selector bit 19 is 1 (root-port mode), a header passes the source filter when selector bit p is 1, where p is hdr_port. Several ports may be selected at once.
- R5: When selector bit 19 is 0 (requester mode), a header passes the source filter only when hdr_rid equals selector bits [15:0]. In this mode the port is ignored.
- R6: The class mask passes posted headers on bit 0, non-posted on bit 1 and completions on bit 2. The hdr_class encoding is 0 = posted, 1 = non-posted, 2 = completion and 3 = other. Class 3 never passes.
- R7: In 4DW format (fmt_8dw = 0), direction code 0 passes inbound headers only, code 1 passes outbound headers only, and codes 2 and 3 pass both directions.
- R8: In 8DW format, direction code 1 passes outbound headers. Code 2 passes inbound posted, non-posted and type-B completions (hdr_cpl_b = 1). Code 3 passes only inbound type-A completions (hdr_cpl_b = 0).
- R9: While trace is active, changes to the setup inputs have no effect, and a further start request neither restarts nor reloads the setup.
- R10: A stop request while active clears trace_active on the next cycle. A header presented in the cycle of that stop request is still judged. A header presented in the cycle of the start request is not captured.
- R11: From the error state, a start request with a legal setup enters the active state and clears config_error. A stop request clears config_error and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_sel | input | 20 | Source selector: bit 19 selects the mode, bits [15:0] hold the port mask or requester ID |
| cfg_class_mask | input | 8 | Class mask: bit 0 posted, bit 1 non-posted, bit 2 completion |
| cfg_dir_code | input | 4 | Direction code |
| cfg_fmt_8dw | input | 1 | Record size: 0 = 4DW, 1 = 8DW |
| trace_start | input | 1 | Start request pulse |
| trace_stop | input | 1 | Stop request pulse |
| hdr_valid | input | 1 | Header observed this cycle |
| hdr_outbound | input | 1 | 1 = outbound, 0 = inbound |
| hdr_class | input | 2 | Header class |
| hdr_cpl_b | input | 1 | Inbound completion subtype: 1 = type B, 0 = type A |
| hdr_port | input | PORT_W | Root-port index |
| hdr_rid | input | 16 | Requester ID |
| capture | output | 1 | Capture strobe to the record formatter |
| trace_active | output | 1 | Trace is running |
| config_error | output | 1 | Last start request was rejected |

## Verification
Two pairs of functions can fall in the same cycle: a control transition and a header decision. The bench raises hdr_valid together with trace_start, and later together with trace_stop, for headers that would otherwise pass. It expects no capture for the start-cycle header and a capture for the stop-cycle header, because the decision uses the state that was held before the edge. The bench also changes the setup inputs and pulses start in the middle of a run, then sends headers that only the new setup would pass, to show that the latched setup still governs.

// File: rtl/tlp_trace_pkg.sv
package tlp_trace_pkg;

    localparam int SEL_W   = 20;
    localparam int FVAL_W  = 16;
    localparam int MASK_W  = 8;
    localparam int DIR_W   = 4;
    localparam int RP_BIT  = 19;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ERR  = 2'd2
    } trc_state_e;

    typedef enum logic [1:0] {
        CLS_POSTED  = 2'd0,
        CLS_NONPOST = 2'd1,
        CLS_CPL     = 2'd2,
        CLS_OTHER   = 2'd3
    } tlp_class_e;

    // Fields of the setup that the matcher needs once a run is under way.
    typedef struct packed {
        logic              rp_mode;
        logic [FVAL_W-1:0] fval;
        logic [2:0]        cls_mask;
        logic [1:0]        dir;
        logic              fmt_8dw;
    } trc_cfg_t;

endpackage

// File: rtl/trc_cfg_check.sv
module trc_cfg_check
    import tlp_trace_pkg::*;
(
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [MASK_W-1:0] class_mask,
    input  logic [DIR_W-1:0]  dir_code,
    input  logic              fmt_8dw,
    output logic              legal
);

    logic dir_ok;
    logic has_out;
    logic one_cls;
    logic mask_ok;

    always_comb begin
        if (fmt_8dw) begin
            dir_ok  = (dir_code == 4'd1) || (dir_code == 4'd2) || (dir_code == 4'd3);
            has_out = (dir_code == 4'd1);
        end else begin
            dir_ok  = (dir_code[3:2] == 2'b00);
            has_out = (dir_code != 4'd0);
        end
        one_cls = (class_mask[2:0] == 3'b001) || (class_mask[2:0] == 3'b010)
               || (class_mask[2:0] == 3'b100);
        mask_ok = (class_mask[2:0] != 3'b000) && (class_mask[MASK_W-1:3] == '0);
        legal   = dir_ok && mask_ok && (src_sel[18:16] == 3'b000)
               && (!has_out || one_cls);
    end

endmodule

// File: rtl/trc_hdr_match.sv
module trc_hdr_match
    import tlp_trace_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  trc_cfg_t          cfg,
    input  logic              outbound,
    input  logic [1:0]        cls,
    input  logic              cpl_b,
    input  logic [PORT_W-1:0] port,
    input  logic [15:0]       rid,
    output logic              hit
);

    logic [NUM_PORTS-1:0] port_hit;
    logic src_ok;
    logic cls_ok;
    logic dir_ok;
    logic is_cpl;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign port_hit[p] = cfg.fval[p] && (port == PORT_W'(p));
        end
    endgenerate

    assign is_cpl = (cls == CLS_CPL);

    always_comb begin
        src_ok = cfg.rp_mode ? (|port_hit) : (rid == cfg.fval);
        unique case (cls)
            CLS_POSTED:  cls_ok = cfg.cls_mask[0];
            CLS_NONPOST: cls_ok = cfg.cls_mask[1];
            CLS_CPL:     cls_ok = cfg.cls_mask[2];
            default:     cls_ok = 1'b0;
        endcase
        if (!cfg.fmt_8dw) begin
            unique case (cfg.dir)
                2'd0:    dir_ok = !outbound;
                2'd1:    dir_ok = outbound;
                default: dir_ok = 1'b1;
            endcase
        end else begin
            unique case (cfg.dir)
                2'd1:    dir_ok = outbound;
                2'd2:    dir_ok = !outbound && (!is_cpl || cpl_b);
                2'd3:    dir_ok = !outbound && is_cpl && !cpl_b;
                default: dir_ok = 1'b0;
            endcase
        end
        hit = src_ok && cls_ok && dir_ok;
    end

endmodule

// File: rtl/tlp_trace_filter.sv
module tlp_trace_filter
    import tlp_trace_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [19:0]       cfg_src_sel,
    input  logic [7:0]        cfg_class_mask,
    input  logic [3:0]        cfg_dir_code,
    input  logic              cfg_fmt_8dw,
    input  logic              trace_start,
    input  logic              trace_stop,
    input  logic              hdr_valid,
    input  logic              hdr_outbound,
    input  logic [1:0]        hdr_class,
    input  logic              hdr_cpl_b,
    input  logic [PORT_W-1:0] hdr_port,
    input  logic [15:0]       hdr_rid,
    output logic              capture,
    output logic              trace_active,
    output logic              config_error
);

    trc_state_e state_q, state_d;
    trc_cfg_t   cfg_q;
    logic       cfg_legal;
    logic       hdr_hit;

    trc_cfg_check u_check (
        .src_sel    (cfg_src_sel),
        .class_mask (cfg_class_mask),
        .dir_code   (cfg_dir_code),
        .fmt_8dw    (cfg_fmt_8dw),
        .legal      (cfg_legal)
    );

    trc_hdr_match #(.NUM_PORTS(NUM_PORTS)) u_match (
        .cfg      (cfg_q),
        .outbound (hdr_outbound),
        .cls      (hdr_class),
        .cpl_b    (hdr_cpl_b),
        .port     (hdr_port),
        .rid      (hdr_rid),
        .hit      (hdr_hit)
    );

    // Next-state logic: launch, reject, halt, recover, clear.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trace_start) state_d = cfg_legal ? ST_RUN : ST_ERR;
            ST_RUN:  if (trace_stop)  state_d = ST_IDLE;
            ST_ERR: begin
                if (trace_start)     state_d = cfg_legal ? ST_RUN : ST_ERR;
                else if (trace_stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, with the setup latched on entry to the run state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_RUN && state_d == ST_RUN) begin
                cfg_q.rp_mode  <= cfg_src_sel[RP_BIT];
                cfg_q.fval     <= cfg_src_sel[FVAL_W-1:0];
                cfg_q.cls_mask <= cfg_class_mask[2:0];
                cfg_q.dir      <= cfg_dir_code[1:0];
                cfg_q.fmt_8dw  <= cfg_fmt_8dw;
            end
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) capture <= 1'b0;
        else        capture <= (state_q == ST_RUN) && hdr_valid && hdr_hit;
    end

    assign trace_active = (state_q == ST_RUN);
    assign config_error = (state_q == ST_ERR);

endmodule

// File: rtl/tlp_trace_filter_chk.sv
module tlp_trace_filter_chk
    import tlp_trace_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     hdr_valid,
    input logic     trace_start,
    input logic     capture,
    input logic     trace_active,
    input logic     config_error,
    input logic     cfg_legal,
    input trc_cfg_t cfg_q
);

    assert_no_idle_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_active |=> !capture);

    assert_capture_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> $past(hdr_valid));

    assert_error_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(config_error && trace_active));

    assert_launch_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trace_active) |-> ($past(trace_start) && $past(cfg_legal)));

    assert_setup_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trace_active) && trace_active) |-> $stable(cfg_q));

endmodule

bind tlp_trace_filter tlp_trace_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hdr_valid    (hdr_valid),
    .trace_start  (trace_start),
    .capture      (capture),
    .trace_active (trace_active),
    .config_error (config_error),
    .cfg_legal    (cfg_legal),
    .cfg_q        (cfg_q)
);

// File: tb/tlp_trace_filter_bench.sv
module tlp_trace_filter_bench;

    localparam int NUM_PORTS = 16;
    localparam int PORT_W    = $clog2(NUM_PORTS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [19:0]       cfg_src_sel = 20'h80001;
    logic [7:0]        cfg_class_mask = 8'h01;
    logic [3:0]        cfg_dir_code = 4'd0;
    logic              cfg_fmt_8dw = 1'b0;
    logic              trace_start = 1'b0;
    logic              trace_stop = 1'b0;
    logic              hdr_valid = 1'b0;
    logic              hdr_outbound = 1'b0;
    logic [1:0]        hdr_class = 2'd0;
    logic              hdr_cpl_b = 1'b0;
    logic [PORT_W-1:0] hdr_port = '0;
    logic [15:0]       hdr_rid = 16'h0;
    logic              capture;
    logic              trace_active;
    logic              config_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tlp_trace_filter #(.NUM_PORTS(NUM_PORTS)) u_tlp_trace_filter (
        .clk, .rst_n, .cfg_src_sel, .cfg_class_mask, .cfg_dir_code, .cfg_fmt_8dw,
        .trace_start, .trace_stop, .hdr_valid, .hdr_outbound, .hdr_class,
        .hdr_cpl_b, .hdr_port, .hdr_rid, .capture, .trace_active, .config_error
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [19:0] sel, input logic [7:0] msk,
                         input logic [3:0] dir, input logic fmt);
        @(negedge clk);
        cfg_src_sel = sel; cfg_class_mask = msk; cfg_dir_code = dir; cfg_fmt_8dw = fmt;
    endtask

    task automatic start(input logic exp_act, input logic exp_err, input string tag);
        @(negedge clk); trace_start = 1'b1;
        @(negedge clk); trace_start = 1'b0;
        check(trace_active, exp_act, {tag, " active"});
        check(config_error, exp_err, {tag, " config_error"});
    endtask

    task automatic stop();
        @(negedge clk); trace_stop = 1'b1;
        @(negedge clk); trace_stop = 1'b0;
    endtask

    task automatic send(input logic outb, input logic [1:0] cls, input logic cplb,
                        input int port, input logic [15:0] rid,
                        input logic exp, input string tag);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_outbound = outb; hdr_class = cls; hdr_cpl_b = cplb;
        hdr_port = PORT_W'(port); hdr_rid = rid;
        @(negedge clk); hdr_valid = 1'b0;
        check(capture, exp, tag);
    endtask

    task automatic t_reset();
        check(trace_active, 1'b0, "R1 active");
        check(config_error, 1'b0, "R1 error");
        check(capture, 1'b0, "R1 capture");
    endtask

    task automatic t_root_port();
        setup(20'h80005, 8'h07, 4'd0, 1'b0);
        start(1'b1, 1'b0, "R2 legal");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b1, "R4 port0");
        @(negedge clk); check(capture, 1'b0, "R3 single pulse");
        send(1'b0, 2'd0, 1'b0, 1, 16'h0, 1'b0, "R4 port1");
        send(1'b0, 2'd2, 1'b1, 2, 16'h0, 1'b1, "R4 port2");
        send(1'b1, 2'd0, 1'b0, 0, 16'h0, 1'b0, "R7 code0 outbound");
        send(1'b0, 2'd3, 1'b0, 0, 16'h0, 1'b0, "R6 other class");
        stop();
        check(trace_active, 1'b0, "R10 stop");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b0, "R3 idle");
    endtask

    task automatic t_requester();
        setup(20'h00101, 8'h07, 4'd0, 1'b0);
        start(1'b1, 1'b0, "R5 start");
        send(1'b0, 2'd1, 1'b0, 5, 16'h0101, 1'b1, "R5 match");
        send(1'b0, 2'd1, 1'b0, 1, 16'h0102, 1'b0, "R5 mismatch");
        stop();
    endtask

    task automatic t_classes();
        setup(20'h80001, 8'h02, 4'd0, 1'b0);
        start(1'b1, 1'b0, "R6 start");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b0, "R6 posted");
        send(1'b0, 2'd1, 1'b0, 0, 16'h0, 1'b1, "R6 nonposted");
        send(1'b0, 2'd2, 1'b0, 0, 16'h0, 1'b0, "R6 cpl");
        stop();
    endtask

    task automatic t_dir_4dw();
        setup(20'h80001, 8'h01, 4'd1, 1'b0);
        start(1'b1, 1'b0, "R7 code1");
        send(1'b1, 2'd0, 1'b0, 0, 16'h0, 1'b1, "R7 code1 out");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b0, "R7 code1 in");
        stop();
        setup(20'h80001, 8'h01, 4'd2, 1'b0);
        start(1'b1, 1'b0, "R7 code2");
        send(1'b1, 2'd0, 1'b0, 0, 16'h0, 1'b1, "R7 code2 out");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b1, "R7 code2 in");
        stop();
    endtask

    task automatic t_dir_8dw();
        setup(20'h80001, 8'h07, 4'd2, 1'b1);
        start(1'b1, 1'b0, "R8 code2");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b1, "R8 code2 posted");
        send(1'b0, 2'd2, 1'b1, 0, 16'h0, 1'b1, "R8 code2 cplB");
        send(1'b0, 2'd2, 1'b0, 0, 16'h0, 1'b0, "R8 code2 cplA");
        send(1'b1, 2'd0, 1'b0, 0, 16'h0, 1'b0, "R8 code2 out");
        stop();
        setup(20'h80001, 8'h04, 4'd3, 1'b1);
        start(1'b1, 1'b0, "R8 code3");
        send(1'b0, 2'd2, 1'b0, 0, 16'h0, 1'b1, "R8 code3 cplA");
        send(1'b0, 2'd2, 1'b1, 0, 16'h0, 1'b0, "R8 code3 cplB");
        stop();
        setup(20'h80001, 8'h01, 4'd1, 1'b1);
        start(1'b1, 1'b0, "R8 code1");
        send(1'b1, 2'd0, 1'b0, 0, 16'h0, 1'b1, "R8 code1 out");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b0, "R8 code1 in");
        stop();
    endtask

    task automatic t_illegal();
        setup(20'h80001, 8'h01, 4'd0, 1'b1);
        start(1'b0, 1'b1, "R2 8dw code0");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b0, "R2 no capture in error");
        setup(20'h80001, 8'h00, 4'd0, 1'b0);
        start(1'b0, 1'b1, "R2 empty mask");
        setup(20'h80001, 8'h03, 4'd1, 1'b0);
        start(1'b0, 1'b1, "R2 outbound two classes");
        setup(20'h80001, 8'h01, 4'd5, 1'b0);
        start(1'b0, 1'b1, "R2 4dw code5");
        setup(20'h90001, 8'h01, 4'd0, 1'b0);
        start(1'b0, 1'b1, "R2 selector reserved");
        setup(20'h80001, 8'h09, 4'd0, 1'b0);
        start(1'b0, 1'b1, "R2 mask reserved");
        stop();
        check(config_error, 1'b0, "R11 stop clears");
        setup(20'h80001, 8'h00, 4'd0, 1'b0);
        start(1'b0, 1'b1, "R2 reject again");
        setup(20'h80001, 8'h03, 4'd0, 1'b0);
        start(1'b1, 1'b0, "R11 recover");
        send(1'b0, 2'd1, 1'b0, 0, 16'h0, 1'b1, "R11 capture after recover");
        stop();
    endtask

    task automatic t_frozen();
        setup(20'h80001, 8'h01, 4'd0, 1'b0);
        start(1'b1, 1'b0, "R9 start");
        setup(20'h80002, 8'h02, 4'd1, 1'b0);
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b1, "R9 old setup kept");
        send(1'b1, 2'd1, 1'b0, 1, 16'h0, 1'b0, "R9 new setup ignored");
        start(1'b1, 1'b0, "R9 restart ignored");
        send(1'b1, 2'd1, 1'b0, 1, 16'h0, 1'b0, "R9 no reload");
        send(1'b0, 2'd0, 1'b0, 0, 16'h0, 1'b1, "R9 still old");
        stop();
    endtask

    task automatic t_same_cycle();
        setup(20'h80001, 8'h01, 4'd0, 1'b0);
        @(negedge clk);
        trace_start = 1'b1; hdr_valid = 1'b1; hdr_outbound = 1'b0;
        hdr_class = 2'd0; hdr_port = '0;
        @(negedge clk);
        trace_start = 1'b0; hdr_valid = 1'b0;
        check(capture, 1'b0, "R10 start-cycle header");
        check(trace_active, 1'b1, "R10 active after start");
        @(negedge clk);
        trace_stop = 1'b1; hdr_valid = 1'b1;
        @(negedge clk);
        trace_stop = 1'b0; hdr_valid = 1'b0;
        check(capture, 1'b1, "R10 stop-cycle header");
        check(trace_active, 1'b0, "R10 idle after stop");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_root_port();
        t_requester();
        t_classes();
        t_dir_4dw();
        t_dir_8dw();
        t_illegal();
        t_frozen();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule